// File: doc/BRIEF.md
# IDLE-Based Receive Rate Matcher

This block is the elastic buffer on a receive path. It sits after the 8B/10B decoder and before the local word-clock logic. Decoded words enter on the write side together with a flag that marks IDLE words. Words leave on the read side in their original order. Small rate differences between the two sides are absorbed by adjusting the IDLE words only. An IDLE can be withheld from the buffer, or it can be stored twice. Data words are never dropped, duplicated or altered.

A two-bit mode input selects one of four behaviours:

- **`2'b00` (plain)**: no rate correction.
- **`2'b11` (align-only)**: no rate correction, for frequency-locked systems where the stream must pass untouched. Word alignment itself is done outside this block.
- **`2'b01` (independent)**: the block watches its own fill level and decides by itself when to drop or duplicate an IDLE.
- **`2'b10` (coordinated)**: the block acts only on external delete and insert requests. This lets several channels drop or duplicate the same IDLE together.

Both sides are modelled in one clock domain. The rate difference appears as gaps in `wr_valid` and `rd_en`.

Top module: `rate_matcher`

## Requirements
- R1: After reset, `fill` is 0, `err` is 0, `rd_valid` is 0 and `ign_cnt` is 0.
- R2: In modes `2'b00` and `2'b11`, every accepted write stores exactly one entry, whether or not it is an IDLE. Delete and insert requests have no effect in these modes and are not counted.
- R3: An `rd_en` with a non-empty buffer returns the oldest entry on `rd_data`/`rd_idle`, with `rd_valid` high, in the cycle after the read edge. `fill` drops by one at that edge.
- R4: In mode `2'b01`, an IDLE written while `fill` is at least 6 is discarded.
- R5: In mode `2'b01`, an IDLE written while `fill` is at most 2 is stored twice, as two consecutive entries.
- R6: A data word (`wr_idle` low) is always stored once. In mode `2'b01`, an IDLE written with `fill` from 3 to 5 is also stored once.
- R7: In mode `2'b10`, a delete request discards the first IDLE written in a later cycle. Data words written in between are stored.
- R8: In mode `2'b10`, an insert request stores the first IDLE written in a later cycle twice.
- R9: In mode `2'b10`, the fill level triggers no drop or duplicate on its own.
- R10: At most one request is held. A request arriving while one is pending is ignored and increments `ign_cnt`. If delete and insert arrive together with none pending, the delete is kept and the insert is counted as ignored. `ign_cnt` saturates.
- R11: A write that needs more entries than are free stores only what fits and sets `err`. So does a read while empty, which also leaves `rd_valid` low. `err` stays set until reset.
- R12: `fill` always equals the number of stored entries and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 plain, 01 independent, 10 coordinated, 11 align-only |
| wr_valid | input | 1 | A decoded word is offered this cycle |
| wr_data | input | 8 | Decoded word |
| wr_idle | input | 1 | Offered word is an IDLE |
| rd_en | input | 1 | Local side takes one entry |
| req_del | input | 1 | Coordinated request: drop the next IDLE |
| req_ins | input | 1 | Coordinated request: duplicate the next IDLE |
| rd_valid | output | 1 | `rd_data` holds a word read at the previous edge |
| rd_data | output | 8 | Word leaving the buffer |
| rd_idle | output | 1 | IDLE flag of the word leaving |
| fill | output | 4 | Number of stored entries |
| err | output | 1 | Sticky overflow/underflow flag |
| ign_cnt | output | 8 | Count of ignored requests |

## Verification
A wrong drop or duplicate decision is visible at the edge where the IDLE is offered. `fill` then moves by 0, 1 or 2 entries, so the bench compares `fill` after every edge against the value the mode and the old level call for.

A lost or stale pending request stays hidden until the next IDLE. It surfaces one edge later as a wrong `fill` step, and through `ign_cnt` when a second request arrives. Pointer or ordering faults only show when entries are read back, one cycle after `rd_en`, as a wrong word or IDLE flag.

// File: rtl/rm_pkg.sv
// Package: shared types for the IDLE rate matcher.
// Assumes nothing beyond a two-bit mode field driven by the top.
package rm_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_INDEP = 2'b01,
        MODE_COORD = 2'b10,
        MODE_ALIGN = 2'b11
    } rm_mode_e;
endpackage

// File: rtl/rm_ctrl.sv
// rm_ctrl: decides, for the word offered this cycle, whether an IDLE is
// dropped or duplicated. It holds the single pending coordinated request
// and counts the requests it has to ignore.
// Assumes fill is the registered buffer level before the current edge.
module rm_ctrl
    import rm_pkg::*;
#(
    parameter int FW    = 4,
    parameter int HI_TH = 6,
    parameter int LO_TH = 2,
    parameter int CW    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  rm_mode_e       mode,
    input  logic           wr_valid,
    input  logic           wr_idle,
    input  logic [FW-1:0]  fill,
    input  logic           req_del,
    input  logic           req_ins,
    output logic           act_del,
    output logic           act_ins,
    output logic [CW-1:0]  ign_cnt
);
    logic pend_del, pend_ins;
    logic idle_wr, busy, ignored;

    assign idle_wr = wr_valid && wr_idle;
    assign busy    = pend_del || pend_ins;
    assign ignored = (mode == MODE_COORD) && (req_del || req_ins) &&
                     (busy || (req_del && req_ins));

    // Pick the action for the IDLE offered this cycle, per mode.
    always_comb begin
        act_del = 1'b0;
        act_ins = 1'b0;
        case (mode)
            MODE_INDEP: begin
                if (idle_wr && fill >= FW'(HI_TH))      act_del = 1'b1;
                else if (idle_wr && fill <= FW'(LO_TH)) act_ins = 1'b1;
            end
            MODE_COORD: begin
                act_del = idle_wr && pend_del;
                act_ins = idle_wr && pend_ins;
            end
            default: ;
        endcase
    end

    // Hold one request; release it on the IDLE it applies to.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_COORD) begin
            pend_del <= 1'b0;
            pend_ins <= 1'b0;
        end else if (busy) begin
            if (act_del || act_ins) begin
                pend_del <= 1'b0;
                pend_ins <= 1'b0;
            end
        end else if (req_del) begin
            pend_del <= 1'b1;
        end else if (req_ins) begin
            pend_ins <= 1'b1;
        end
    end

    // Saturating count of requests dropped by the single-slot rule.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ign_cnt <= '0;
        else if (ignored && ign_cnt != '1)    ign_cnt <= ign_cnt + 1'b1;
    end

    // R10: never two requests held at once
    a_r10_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_del, pend_ins}));

    // R10: a request while one is pending bumps the counter
    a_r10_ign_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COORD && busy && req_del && ign_cnt != '1)
        |=> ign_cnt == $past(ign_cnt) + CW'(1));

    // R9: coordinated mode with nothing pending takes no action
    a_r9_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COORD && !busy) |-> !(act_del || act_ins));
endmodule

// File: rtl/rm_fifo.sv
// rm_fifo: storage ring for the matcher. Accepts 0, 1 or 2 copies of an
// entry per cycle and pops at most one entry per cycle. Also keeps the
// fill level and the sticky error flag.
// Assumes DEPTH is a power of two. A full buffer does not count a
// simultaneous read as free space.
module rm_fifo #(
    parameter int EW    = 9,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     wr_n,
    input  logic [EW-1:0]  wr_entry,
    input  logic           rd_en,
    output logic [EW-1:0]  rd_entry,
    output logic           rd_valid,
    output logic [FW-1:0]  fill,
    output logic           err
);
    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [FW-1:0] space, want, n_acc;
    logic          pop, ovf, unf;

    assign space = FW'(DEPTH) - fill;
    assign want  = {{(FW-2){1'b0}}, wr_n};
    assign ovf   = want > space;
    assign n_acc = ovf ? space : want;
    assign pop   = rd_en && (fill != '0);
    assign unf   = rd_en && (fill == '0);

    // Store the accepted copies at consecutive slots.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (FW'(i) < n_acc) mem[wp + AW'(i)] <= wr_entry;
        end
    end

    // Advance pointers and the level; register the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            fill     <= '0;
            rd_valid <= 1'b0;
            rd_entry <= '0;
        end else begin
            wp       <= wp + n_acc[AW-1:0];
            rp       <= rp + AW'(pop);
            fill     <= fill + n_acc - FW'(pop);
            rd_valid <= pop;
            if (pop) rd_entry <= mem[rp];
        end
    end

    // Latch any overflow or underflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= err || ovf || unf;
    end

    // R12: level never exceeds capacity
    a_r12_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    // R11: error flag is sticky
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R3: a read of a non-empty buffer yields a word next cycle
    a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill != '0) |=> rd_valid);

    // R11: a read on an empty buffer yields no word and raises the flag
    a_r11_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill == '0) |=> (!rd_valid && err));
endmodule

// File: rtl/rate_matcher.sv
// rate_matcher: IDLE-based receive elastic buffer. Combines the decision
// logic with the storage ring. A dropped IDLE is simply not written; a
// duplicated IDLE is written into two slots in the same cycle.
// Assumes both sides share clk; rate differences come from enable gaps.
module rate_matcher
    import rm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int HI_TH  = 6,
    parameter int LO_TH  = 2,
    parameter int CNT_W  = 8,
    localparam int FW    = $clog2(DEPTH) + 1,
    localparam int EW    = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_idle,
    input  logic              rd_en,
    input  logic              req_del,
    input  logic              req_ins,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_idle,
    output logic [FW-1:0]     fill,
    output logic              err,
    output logic [CNT_W-1:0]  ign_cnt
);
    rm_mode_e      mode_e;
    logic          act_del, act_ins;
    logic [1:0]    wr_n;
    logic [EW-1:0] rd_entry;

    assign mode_e = rm_mode_e'(mode);

    // Number of copies of the offered word to store.
    always_comb begin
        if (!wr_valid || act_del) wr_n = 2'd0;
        else if (act_ins)         wr_n = 2'd2;
        else                      wr_n = 2'd1;
    end

    rm_ctrl #(
        .FW(FW), .HI_TH(HI_TH), .LO_TH(LO_TH), .CW(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode_e),
        .wr_valid(wr_valid), .wr_idle(wr_idle), .fill(fill),
        .req_del(req_del), .req_ins(req_ins),
        .act_del(act_del), .act_ins(act_ins), .ign_cnt(ign_cnt)
    );

    rm_fifo #(
        .EW(EW), .DEPTH(DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n),
        .wr_entry({wr_idle, wr_data}), .rd_en(rd_en),
        .rd_entry(rd_entry), .rd_valid(rd_valid), .fill(fill), .err(err)
    );

    assign rd_idle = rd_entry[EW-1];
    assign rd_data = rd_entry[DATA_W-1:0];

    // R2: rate-neutral modes store exactly one entry per write
    a_r2_pass_once: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b00 || mode == 2'b11) && wr_valid && !rd_en &&
         fill < FW'(DEPTH)) |=> fill == $past(fill) + FW'(1));

    // R6: a data word is always stored once
    a_r6_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_idle && !rd_en && fill < FW'(DEPTH))
        |=> fill == $past(fill) + FW'(1));

    // R4: independent mode drops an IDLE at a high level
    a_r4_indep_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && wr_valid && wr_idle && !rd_en &&
         fill >= FW'(HI_TH)) |=> fill == $past(fill));
endmodule

// File: tb/tb_rate_matcher.sv
module tb_rate_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wr_valid = 1'b0, wr_idle = 1'b0, rd_en = 1'b0;
    logic       req_del = 1'b0, req_ins = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_valid, rd_idle, err;
    logic [7:0] rd_data, ign_cnt;
    logic [3:0] fill;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    rate_matcher dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_idle(wr_idle), .rd_en(rd_en),
        .req_del(req_del), .req_ins(req_ins), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_idle(rd_idle), .fill(fill), .err(err),
        .ign_cnt(ign_cnt)
    );

    // {mode, wr_valid, wr_idle, wr_data, rd_en, req_del, req_ins, exp_fill}
    localparam int NV = 29;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 4'd1},  // R2
        {2'd0, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 idle once
        {2'd0, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b1, 4'd3},  // R2 req no effect
        {2'd0, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd4},  // R2
        {2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
        {2'd1, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd4},  // R6 mid level
        {2'd1, 1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 4'd5},  // R6
        {2'd1, 1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {2'd1, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd6},  // R4 drop
        {2'd1, 1'b1, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 4'd7},  // R6 data kept
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd6},  // R3
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd5},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd2},
        {2'd1, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd4},  // R5 duplicate
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd2},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd1},
        {2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0},
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd1},  // R9 low level
        {2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd1},  // R7 request
        {2'd2, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 4'd2},  // R7 data kept
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd2},  // R7 idle gone
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd3},  // R7 once only
        {2'd2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd3},  // R8 request
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd5},  // R8 duplicate
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd6},
        {2'd2, 1'b1, 1'b1, 8'hBC, 1'b0, 1'b0, 1'b0, 4'd7}   // R9 high level
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, return after the rise.
    task automatic step(input bit wv, input bit idl, input logic [7:0] d,
                        input bit rd, input bit rdel, input bit rins);
        @(negedge clk);
        wr_valid = wv; wr_idle = idl; wr_data = d;
        rd_en = rd; req_del = rdel; req_ins = rins;
        @(posedge clk);
        #1;
        wr_valid = 1'b0; wr_idle = 1'b0; rd_en = 1'b0;
        req_del = 1'b0; req_ins = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(0, 0, 8'h00, 0, 0, 0);
        step(0, 0, 8'h00, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        check(fill == 0, "R1 fill", fill, 0);
        check(err == 0, "R1 err", err, 0);
        check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        check(ign_cnt == 0, "R1 ign_cnt", ign_cnt, 0);

        // Table walk: fill after every edge, no error raised
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][18:17];
            step(VEC[i][16], VEC[i][15], VEC[i][14:7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check(fill == VEC[i][3:0], $sformatf("R12 vector %0d fill", i), fill, VEC[i][3:0]);
            check(err == 0, $sformatf("R11 vector %0d err", i), err, 0);
        end
        check(ign_cnt == 0, "R2 requests outside coordinated mode not counted", ign_cnt, 0);

        // R3/R2: order and flags through a plain pass
        mode = 2'b00;
        do_reset();
        step(1, 0, 8'hA1, 0, 0, 0);
        step(1, 1, 8'hB2, 0, 0, 0);
        step(1, 0, 8'hC3, 0, 0, 0);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_valid && rd_data == 8'hA1 && !rd_idle, "R3 first word", rd_data, 8'hA1);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_valid && rd_data == 8'hB2 && rd_idle, "R2 idle kept", rd_data, 8'hB2);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_valid && rd_data == 8'hC3 && !rd_idle, "R3 third word", rd_data, 8'hC3);
        step(0, 0, 8'h00, 0, 0, 0);
        check(rd_valid == 0, "R3 valid drops", rd_valid, 0);

        // R5: duplicate sits right after the original
        mode = 2'b01;
        do_reset();
        step(1, 1, 8'h55, 0, 0, 0);
        step(1, 0, 8'h66, 0, 0, 0);
        check(fill == 3, "R5 fill", fill, 3);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_data == 8'h55 && rd_idle, "R5 copy one", rd_data, 8'h55);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_data == 8'h55 && rd_idle, "R5 copy two", rd_data, 8'h55);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_data == 8'h66 && !rd_idle, "R6 data after copies", rd_data, 8'h66);

        // R10: single pending slot and ignore count
        mode = 2'b10;
        do_reset();
        step(0, 0, 8'h00, 0, 1, 0);
        step(0, 0, 8'h00, 0, 0, 1);
        check(ign_cnt == 1, "R10 insert ignored", ign_cnt, 1);
        step(0, 0, 8'h00, 0, 1, 0);
        check(ign_cnt == 2, "R10 delete ignored", ign_cnt, 2);
        step(1, 1, 8'hBC, 0, 0, 0);
        check(fill == 0, "R7 pending delete applied", fill, 0);
        step(1, 1, 8'hBC, 0, 0, 0);
        check(fill == 1, "R10 ignored insert had no effect", fill, 1);
        step(0, 0, 8'h00, 0, 1, 1);
        check(ign_cnt == 3, "R10 simultaneous insert counted", ign_cnt, 3);
        step(1, 1, 8'hBC, 0, 0, 0);
        check(fill == 1, "R10 delete wins", fill, 1);

        // R11: overflow keeps contents, flag sticks
        mode = 2'b00;
        do_reset();
        for (int k = 0; k < 8; k++) step(1, 0, 8'(k + 16), 0, 0, 0);
        check(fill == 8 && err == 0, "R12 full", fill, 8);
        step(1, 0, 8'hEE, 0, 0, 0);
        check(err == 1, "R11 overflow err", err, 1);
        check(fill == 8, "R11 overflow fill", fill, 8);
        step(0, 0, 8'h00, 1, 0, 0);
        check(rd_data == 8'h10, "R11 oldest intact", rd_data, 8'h10);
        for (int k = 0; k < 7; k++) step(0, 0, 8'h00, 1, 0, 0);
        check(rd_data == 8'h17, "R11 extra word not stored", rd_data, 8'h17);
        check(fill == 0 && err == 1, "R11 err sticky", err, 1);

        // R11: underflow
        do_reset();
        check(err == 0, "R1 err cleared", err, 0);
        step(0, 0, 8'h00, 1, 0, 0);
        check(err == 1 && rd_valid == 0, "R11 underflow", err, 1);
        check(fill == 0, "R12 empty stays", fill, 0);

        // R2: align-only mode with requests
        mode = 2'b11;
        do_reset();
        step(0, 0, 8'h00, 0, 1, 0);
        step(1, 1, 8'hBC, 0, 0, 0);
        check(fill == 1, "R2 align-only idle kept", fill, 1);
        check(ign_cnt == 0, "R2 align-only no count", ign_cnt, 0);

        finish_run();
    end
endmodule